// File: doc/BRIEF.md
# E1 Performance Monitor Alarm Latch and Error Counter Bank

This block accumulates performance events from an E1 receive framer and reports them to a host. The framer gives it single-cycle pulses. Three of them are error events: a frame alignment word received with bit errors, a bipolar line-code violation, and a CRC-4 block error. Seven are alarm events: remote alarm (received A bit equal to one), all-ones, all-ones in timeslot 16, loss of signal, auxiliary pattern, multiframe alarm and elastic buffer slip. The block keeps a saturating counter for each error class and one sticky bit for each alarm.

The host uses a synchronous strobe interface. A read or write strobe comes with a page number and a byte address. Read data is registered, and the host reads counters wider than eight bits as a high byte and a low byte. A read of the high byte freezes a copy of the low byte, so the two halves of the count match. Reading the alarm latch returns its contents and clears it. Writing to any address of a counter clears that counter.

Top module: `e1_pm_regbank`

## Requirements
- R1: Page 4, address 0x1A reads the 8-bit errored-alignment counter, which adds one for each cycle where `ev_fas_err` is high.
- R2: The 16-bit bipolar violation counter adds one for each `ev_bpv` pulse. Its bits 15..8 read at page 4, address 0x1C and its bits 7..0 at address 0x1D.
- R3: The 10-bit CRC-4 error counter adds one for each `ev_crc_err` pulse. Address 0x1E returns its bits 9..8 in data bits 1..0, with data bits 7..2 zero. Address 0x1F returns its bits 7..0.
- R4: The alarm latch reads at page 4, address 0x1B. Data bit k+1 holds the latch for `alarm_ev[k]`, so bit 7 is remote alarm, bit 6 all-ones, bit 5 all-ones in timeslot 16, bit 4 loss of signal, bit 3 auxiliary pattern, bit 2 multiframe alarm and bit 1 slip. Data bit 0 always reads zero.
- R5: A latch bit is set in the cycle after its event pulse. It stays set until a read of 0x1B, which returns the set bits and then clears them.
- R6: If an alarm event arrives in the same cycle as the clearing read of 0x1B, that bit is still set after the read.
- R7: Each counter stops at all ones and never wraps to zero.
- R8: A write strobe to any address of a counter (0x1A, 0x1C/0x1D or 0x1E/0x1F on page 4) sets that whole counter to zero. If the counter's event arrives in the same cycle, the counter is set to one instead.
- R9: A read of 0x1C (or 0x1E) captures the counter's low byte at that moment. The next read of 0x1D (or 0x1F) returns the captured byte and releases the capture. A low-byte read with no capture pending, or after a clear, returns the live low byte.
- R10: A read on any page other than 4, or at an address outside 0x1A..0x1F, returns 0x00 and changes no state. A write there, or to 0x1B, has no effect.
- R11: With `rst` high at a clock edge, all counters, latch bits, captures and `host_rdata` become zero.
- R12: `host_rdata` takes the read value at the edge that samples `host_rd`, so the value is available the next cycle. It holds while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_fas_err | input | 1 | Errored alignment word event pulse |
| ev_bpv | input | 1 | Bipolar violation event pulse |
| ev_crc_err | input | 1 | CRC-4 block error event pulse |
| alarm_ev | input | 7 | Alarm event pulses, bit k sets latch bit k+1 |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe (clears a counter) |
| host_page | input | PAGE_W | Host page number |
| host_addr | input | 8 | Host byte address |
| host_rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with the default parameter values: a 16-bit violation counter, a 10-bit CRC counter, an 8-bit alignment counter and low-byte capture enabled. With those values the 10-bit counter has its odd high-byte packing, and both split-read paths use the capture logic. The violation counter fills in about 65k pulses, so a directed run drives it into saturation within the cycle limit. Random reads, writes and events on pages 3 to 5 and addresses 0x18 to 0x21 mix clears, captures, coincident events and unmapped accesses.

// File: rtl/e1_pm_pkg.sv
package e1_pm_pkg;

   localparam int N_ALARM = 7;

   localparam logic [7:0] ADR_FAS    = 8'h1A;
   localparam logic [7:0] ADR_ALM    = 8'h1B;
   localparam logic [7:0] ADR_BPV_HI = 8'h1C;
   localparam logic [7:0] ADR_BPV_LO = 8'h1D;
   localparam logic [7:0] ADR_CRC_HI = 8'h1E;
   localparam logic [7:0] ADR_CRC_LO = 8'h1F;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_FAS,
      SEL_ALM,
      SEL_BPV_HI,
      SEL_BPV_LO,
      SEL_CRC_HI,
      SEL_CRC_LO
   } rsel_e;

   function automatic rsel_e addr_decode(input logic [7:0] a);
      case (a)
         ADR_FAS:    return SEL_FAS;
         ADR_ALM:    return SEL_ALM;
         ADR_BPV_HI: return SEL_BPV_HI;
         ADR_BPV_LO: return SEL_BPV_LO;
         ADR_CRC_HI: return SEL_CRC_HI;
         ADR_CRC_LO: return SEL_CRC_LO;
         default:    return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/e1_sat_counter.sv
module e1_sat_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = '1;
   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (clr)
         q <= inc ? ONE : '0;
      else if (inc && q != TOP)
         q <= q + ONE;
   end
endmodule

// File: rtl/e1_alarm_latch.sv
module e1_alarm_latch #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic [N-1:0] set,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst)
            q[i] <= 1'b0;
         else
            q[i] <= (q[i] & ~clr) | set[i];
      end
   end
endmodule

// File: rtl/e1_split_reader.sv
module e1_split_reader #(
   parameter int W       = 16,
   parameter bit SNAP_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] cnt,
   input  logic         rd_hi,
   input  logic         rd_lo,
   input  logic         clr,
   output logic [7:0]   hi_byte,
   output logic [7:0]   lo_byte
);
   logic [15:0] ext;
   assign ext     = 16'(cnt);
   assign hi_byte = ext[15:8];

   if (SNAP_EN) begin : g_snap
      logic [7:0] snap_q;
      logic       armed_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            snap_q  <= '0;
            armed_q <= 1'b0;
         end else if (clr) begin
            armed_q <= 1'b0;
         end else if (rd_hi) begin
            snap_q  <= ext[7:0];
            armed_q <= 1'b1;
         end else if (rd_lo) begin
            armed_q <= 1'b0;
         end
      end
      assign lo_byte = armed_q ? snap_q : ext[7:0];
   end else begin : g_live
      logic unused_ok;
      assign unused_ok = ^{clk, rst, rd_hi, rd_lo, clr};
      assign lo_byte   = ext[7:0];
   end
endmodule

// File: rtl/e1_pm_regbank.sv
module e1_pm_regbank
   import e1_pm_pkg::*;
#(
   parameter int PAGE_W   = 4,
   parameter int MON_PAGE = 4,
   parameter int FAS_W    = 8,
   parameter int BPV_W    = 16,
   parameter int CRC_W    = 10,
   parameter bit SNAP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ev_fas_err,
   input  logic              ev_bpv,
   input  logic              ev_crc_err,
   input  logic [6:0]        alarm_ev,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [PAGE_W-1:0] host_page,
   input  logic [7:0]        host_addr,
   output logic [7:0]        host_rdata
);
   if (FAS_W < 1 || FAS_W > 8) begin : g_bad_fas
      $error("FAS_W must lie in 1..8");
   end
   if (BPV_W < 9 || BPV_W > 16) begin : g_bad_bpv
      $error("BPV_W must lie in 9..16");
   end
   if (CRC_W < 9 || CRC_W > 16) begin : g_bad_crc
      $error("CRC_W must lie in 9..16");
   end
   if (MON_PAGE < 0 || MON_PAGE >= (1 << PAGE_W)) begin : g_bad_page
      $error("MON_PAGE does not fit in PAGE_W bits");
   end

   localparam logic [PAGE_W-1:0] PAGE_ID = PAGE_W'(MON_PAGE);

   rsel_e sel;
   logic  rd_hit, wr_hit;
   logic  fas_clr, bpv_clr, crc_clr, latch_rd;

   assign sel      = (host_page == PAGE_ID) ? addr_decode(host_addr) : SEL_NONE;
   assign rd_hit   = host_rd && sel != SEL_NONE;
   assign wr_hit   = host_wr && sel != SEL_NONE;
   assign fas_clr  = wr_hit && sel == SEL_FAS;
   assign bpv_clr  = wr_hit && (sel == SEL_BPV_HI || sel == SEL_BPV_LO);
   assign crc_clr  = wr_hit && (sel == SEL_CRC_HI || sel == SEL_CRC_LO);
   assign latch_rd = rd_hit && sel == SEL_ALM;

   logic [FAS_W-1:0]   fas_cnt;
   logic [BPV_W-1:0]   bpv_cnt;
   logic [CRC_W-1:0]   crc_cnt;
   logic [N_ALARM-1:0] alarm_q;

   e1_sat_counter #(.W(FAS_W)) fas_ctr_i (
      .clk(clk), .rst(rst), .clr(fas_clr), .inc(ev_fas_err), .q(fas_cnt));
   e1_sat_counter #(.W(BPV_W)) bpv_ctr_i (
      .clk(clk), .rst(rst), .clr(bpv_clr), .inc(ev_bpv), .q(bpv_cnt));
   e1_sat_counter #(.W(CRC_W)) crc_ctr_i (
      .clk(clk), .rst(rst), .clr(crc_clr), .inc(ev_crc_err), .q(crc_cnt));

   e1_alarm_latch #(.N(N_ALARM)) alarm_i (
      .clk(clk), .rst(rst), .clr(latch_rd), .set(alarm_ev), .q(alarm_q));

   logic [7:0] bpv_hi, bpv_lo, crc_hi, crc_lo;

   e1_split_reader #(.W(BPV_W), .SNAP_EN(SNAP_EN)) bpv_rd_i (
      .clk(clk), .rst(rst), .cnt(bpv_cnt),
      .rd_hi(rd_hit && sel == SEL_BPV_HI), .rd_lo(rd_hit && sel == SEL_BPV_LO),
      .clr(bpv_clr), .hi_byte(bpv_hi), .lo_byte(bpv_lo));
   e1_split_reader #(.W(CRC_W), .SNAP_EN(SNAP_EN)) crc_rd_i (
      .clk(clk), .rst(rst), .cnt(crc_cnt),
      .rd_hi(rd_hit && sel == SEL_CRC_HI), .rd_lo(rd_hit && sel == SEL_CRC_LO),
      .clr(crc_clr), .hi_byte(crc_hi), .lo_byte(crc_lo));

   logic [7:0] rd_mux;
   always_comb begin
      case (sel)
         SEL_FAS:    rd_mux = 8'(fas_cnt);
         SEL_ALM:    rd_mux = {alarm_q, 1'b0};
         SEL_BPV_HI: rd_mux = bpv_hi;
         SEL_BPV_LO: rd_mux = bpv_lo;
         SEL_CRC_HI: rd_mux = crc_hi;
         SEL_CRC_LO: rd_mux = crc_lo;
         default:    rd_mux = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         host_rdata <= 8'h00;
      else if (host_rd)
         host_rdata <= rd_mux;
   end
endmodule

// File: rtl/e1_pm_checker.sv
module e1_pm_checker #(
   parameter int PAGE_W   = 4,
   parameter int MON_PAGE = 4,
   parameter int FAS_W    = 8,
   parameter int BPV_W    = 16,
   parameter int CRC_W    = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              host_rd,
   input logic [PAGE_W-1:0] host_page,
   input logic [7:0]        host_addr,
   input logic [7:0]        host_rdata,
   input logic [6:0]        alarm_ev,
   input logic [6:0]        alarm_q,
   input logic [FAS_W-1:0]  fas_cnt,
   input logic [BPV_W-1:0]  bpv_cnt,
   input logic [CRC_W-1:0]  crc_cnt,
   input logic              fas_clr,
   input logic              bpv_clr,
   input logic              crc_clr,
   input logic              latch_rd
);
   logic on_page, mapped;
   assign on_page = host_page == PAGE_W'(MON_PAGE);
   assign mapped  = on_page && host_addr >= 8'h1A && host_addr <= 8'h1F;

   // R5: without a clearing read, a set bit stays set
   assert_alarm_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      !latch_rd |=> ((alarm_q & $past(alarm_q)) == $past(alarm_q)));

   // R5: after a clearing read only same-cycle events remain
   assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
      latch_rd |=> (alarm_q == $past(alarm_ev)));

   // R6: an event is never lost
   assert_event_kept_R6: assert property (@(posedge clk) disable iff (rst)
      (alarm_ev != 7'd0) |=> ((alarm_q & $past(alarm_ev)) == $past(alarm_ev)));

   // R4: bit 0 of the latch register reads zero
   assert_latch_bit0_R4: assert property (@(posedge clk) disable iff (rst)
      (host_rd && on_page && host_addr == 8'h1B) |=> (host_rdata[0] == 1'b0));

   // R3: upper bits of the CRC high byte read zero
   assert_crc_hi_pad_R3: assert property (@(posedge clk) disable iff (rst)
      (host_rd && on_page && host_addr == 8'h1E) |=> ((host_rdata >> (CRC_W - 8)) == 8'h00));

   // R7: counters hold at all ones
   assert_no_wrap_fas_R7: assert property (@(posedge clk) disable iff (rst)
      (fas_cnt == '1 && !fas_clr) |=> (fas_cnt == '1));
   assert_no_wrap_bpv_R7: assert property (@(posedge clk) disable iff (rst)
      (bpv_cnt == '1 && !bpv_clr) |=> (bpv_cnt == '1));
   assert_no_wrap_crc_R7: assert property (@(posedge clk) disable iff (rst)
      (crc_cnt == '1 && !crc_clr) |=> (crc_cnt == '1));

   // R8: counters only fall through a clear, and a clear leaves at most one
   assert_monotone_bpv_R8: assert property (@(posedge clk) disable iff (rst)
      !bpv_clr |=> (bpv_cnt >= $past(bpv_cnt)));
   assert_clear_bpv_R8: assert property (@(posedge clk) disable iff (rst)
      bpv_clr |=> (bpv_cnt <= BPV_W'(1)));
   assert_clear_crc_R8: assert property (@(posedge clk) disable iff (rst)
      crc_clr |=> (crc_cnt <= CRC_W'(1)));

   // R10: unmapped reads return zero
   assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
      (host_rd && !mapped) |=> (host_rdata == 8'h00));

   // R12: read data holds between reads
   assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
      !host_rd |=> $stable(host_rdata));

   // R11: reset clears state
   assert_reset_clear_R11: assert property (@(posedge clk)
      rst |=> (host_rdata == 8'h00 && alarm_q == 7'd0 && fas_cnt == '0
               && bpv_cnt == '0 && crc_cnt == '0));
endmodule

bind e1_pm_regbank e1_pm_checker #(
   .PAGE_W(PAGE_W), .MON_PAGE(MON_PAGE), .FAS_W(FAS_W), .BPV_W(BPV_W), .CRC_W(CRC_W)
) chk_i (
   .clk(clk), .rst(rst), .host_rd(host_rd), .host_page(host_page),
   .host_addr(host_addr), .host_rdata(host_rdata), .alarm_ev(alarm_ev),
   .alarm_q(alarm_q), .fas_cnt(fas_cnt), .bpv_cnt(bpv_cnt), .crc_cnt(crc_cnt),
   .fas_clr(fas_clr), .bpv_clr(bpv_clr), .crc_clr(crc_clr), .latch_rd(latch_rd)
);

// File: tb/e1_pm_regbank_tb_top.sv
`timescale 1ns/1ps
module e1_pm_regbank_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ev_fas_err = 1'b0, ev_bpv = 1'b0, ev_crc_err = 1'b0;
   logic [6:0] alarm_ev = 7'd0;
   logic       host_rd = 1'b0, host_wr = 1'b0;
   logic [3:0] host_page = 4'd0;
   logic [7:0] host_addr = 8'd0;
   logic [7:0] host_rdata;

   always #2.5 clk = ~clk;

   e1_pm_regbank dut_i (
      .clk(clk), .rst(rst), .ev_fas_err(ev_fas_err), .ev_bpv(ev_bpv),
      .ev_crc_err(ev_crc_err), .alarm_ev(alarm_ev), .host_rd(host_rd),
      .host_wr(host_wr), .host_page(host_page), .host_addr(host_addr),
      .host_rdata(host_rdata));

   int n_chk = 0, n_bad = 0;

   // reference model built from the requirements
   int         m_fas, m_bpv, m_crc;
   logic [7:0] m_alm;
   logic [7:0] b_snap, c_snap;
   bit         b_arm, c_arm;
   logic [7:0] exp_q;

   function automatic logic [7:0] model_read(logic [3:0] pg, logic [7:0] ad);
      if (pg != 4'd4) return 8'h00;
      case (ad)
         8'h1A: return 8'(m_fas);
         8'h1B: return m_alm;
         8'h1C: return 8'(m_bpv >> 8);
         8'h1D: return b_arm ? b_snap : 8'(m_bpv);
         8'h1E: return 8'(m_crc >> 8);
         8'h1F: return c_arm ? c_snap : 8'(m_crc);
         default: return 8'h00;
      endcase
   endfunction

   function automatic string tag_of(logic [3:0] pg, logic [7:0] ad);
      if (pg != 4'd4) return "R10";
      case (ad)
         8'h1A: return "R1";
         8'h1B: return "R5";
         8'h1C, 8'h1D: return "R2";
         8'h1E, 8'h1F: return "R3";
         default: return "R10";
      endcase
   endfunction

   function automatic int sat_next(int v, bit clr, bit ev, int maxv);
      if (clr) return ev ? 1 : 0;
      if (ev && v < maxv) return v + 1;
      return v;
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h want %02h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_fas = 0; m_bpv = 0; m_crc = 0; m_alm = 8'h00;
      b_snap = 8'h00; c_snap = 8'h00; b_arm = 0; c_arm = 0; exp_q = 8'h00;
   endtask

   task automatic step(bit fe, bit be, bit ce, bit [6:0] ae, bit rd, bit wr,
                       logic [3:0] pg, logic [7:0] ad, string tag);
      bit on4, cf, cb, cc;
      ev_fas_err = fe; ev_bpv = be; ev_crc_err = ce; alarm_ev = ae;
      host_rd = rd; host_wr = wr; host_page = pg; host_addr = ad;
      on4 = (pg == 4'd4);
      if (rd) exp_q = model_read(pg, ad);
      cf = wr && on4 && ad == 8'h1A;
      cb = wr && on4 && (ad == 8'h1C || ad == 8'h1D);
      cc = wr && on4 && (ad == 8'h1E || ad == 8'h1F);
      if (cb) b_arm = 0;
      else if (rd && on4 && ad == 8'h1C) begin b_snap = 8'(m_bpv); b_arm = 1; end
      else if (rd && on4 && ad == 8'h1D) b_arm = 0;
      if (cc) c_arm = 0;
      else if (rd && on4 && ad == 8'h1E) begin c_snap = 8'(m_crc); c_arm = 1; end
      else if (rd && on4 && ad == 8'h1F) c_arm = 0;
      m_fas = sat_next(m_fas, cf, fe, 255);
      m_bpv = sat_next(m_bpv, cb, be, 65535);
      m_crc = sat_next(m_crc, cc, ce, 1023);
      if (rd && on4 && ad == 8'h1B) m_alm = 8'h00;
      m_alm = m_alm | {ae, 1'b0};
      @(posedge clk);
      @(negedge clk);
      ev_fas_err = 0; ev_bpv = 0; ev_crc_err = 0; alarm_ev = 7'd0;
      host_rd = 0; host_wr = 0;
      if (rd) check(tag == "" ? tag_of(pg, ad) : tag, host_rdata, exp_q);
   endtask

   task automatic rd_at(logic [3:0] pg, logic [7:0] ad, string tag);
      step(0, 0, 0, 7'd0, 1, 0, pg, ad, tag);
   endtask

   task automatic wr_at(logic [7:0] ad);
      step(0, 0, 0, 7'd0, 0, 1, 4'd4, ad, "");
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 7'd0, 0, 0, 4'd0, 8'd0, "");
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_reset();
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout want completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      model_reset();
      do_reset();

      // R11: reset state
      check("R11", host_rdata, 8'h00);
      for (int a = 8'h1A; a <= 8'h1F; a++) rd_at(4'd4, 8'(a), "R11");

      // R4: each alarm lands in its own bit
      for (int k = 0; k < 7; k++) begin
         step(0, 0, 0, 7'(1 << k), 0, 0, 4'd0, 8'd0, "");
         rd_at(4'd4, 8'h1B, "R4");
      end
      rd_at(4'd4, 8'h1B, "R5");

      // R6: event coinciding with clearing read survives
      step(0, 0, 0, 7'b1000001, 0, 0, 4'd0, 8'd0, "");
      step(0, 0, 0, 7'b0000001, 1, 0, 4'd4, 8'h1B, "R6");
      rd_at(4'd4, 8'h1B, "R6");

      // R10: other page and unmapped reads return zero, no clear
      step(0, 0, 0, 7'b0010000, 0, 0, 4'd0, 8'd0, "");
      rd_at(4'd3, 8'h1B, "R10");
      rd_at(4'd4, 8'h20, "R10");
      step(0, 0, 0, 7'd0, 0, 1, 4'd4, 8'h1B, "");
      rd_at(4'd4, 8'h1B, "R10");

      // R12: data holds while idle
      idle(3);
      check("R12", host_rdata, exp_q);

      // R7: saturation of all three counters
      for (int i = 0; i < 260; i++) step(1, 0, 0, 7'd0, 0, 0, 4'd0, 8'd0, "");
      rd_at(4'd4, 8'h1A, "R7");
      for (int i = 0; i < 1030; i++) step(0, 0, 1, 7'd0, 0, 0, 4'd0, 8'd0, "");
      rd_at(4'd4, 8'h1E, "R7");
      rd_at(4'd4, 8'h1F, "R7");
      for (int i = 0; i < 65540; i++) step(0, 1, 0, 7'd0, 0, 0, 4'd0, 8'd0, "");
      rd_at(4'd4, 8'h1C, "R7");
      rd_at(4'd4, 8'h1D, "R7");

      // R8: clears, with and without coincident event
      wr_at(8'h1D);
      rd_at(4'd4, 8'h1C, "R8");
      rd_at(4'd4, 8'h1D, "R8");
      step(1, 0, 0, 7'd0, 0, 1, 4'd4, 8'h1A, "");
      rd_at(4'd4, 8'h1A, "R8");
      wr_at(8'h1E);
      rd_at(4'd4, 8'h1F, "R8");
      step(0, 1, 0, 7'd0, 0, 1, 4'd3, 8'h1C, "");
      rd_at(4'd4, 8'h1D, "R10");

      // R9: capture on high read, live value afterwards
      for (int i = 0; i < 300; i++) step(0, 1, 0, 7'd0, 0, 0, 4'd0, 8'd0, "");
      rd_at(4'd4, 8'h1C, "R9");
      for (int i = 0; i < 5; i++) step(0, 1, 0, 7'd0, 0, 0, 4'd0, 8'd0, "");
      rd_at(4'd4, 8'h1D, "R9");
      rd_at(4'd4, 8'h1D, "R9");
      rd_at(4'd4, 8'h1E, "R9");
      wr_at(8'h1F);
      rd_at(4'd4, 8'h1F, "R9");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         bit fe, be, ce, rd, wr;
         bit [6:0] ae;
         logic [3:0] pg;
         logic [7:0] ad;
         int op;
         fe = ($urandom % 8) == 0;
         be = ($urandom % 3) == 0;
         ce = ($urandom % 6) == 0;
         for (int k = 0; k < 7; k++) ae[k] = ($urandom % 10) == 0;
         pg = (($urandom % 8) == 0) ? ((($urandom % 2) == 0) ? 4'd3 : 4'd5) : 4'd4;
         ad = 8'h18 + 8'($urandom % 10);
         op = $urandom % 100;
         rd = op < 35;
         wr = (op >= 35) && (op < 42);
         step(fe, be, ce, ae, rd, wr, pg, ad, "");
      end

      // R11: mid-run reset
      step(1, 1, 1, 7'h7F, 0, 0, 4'd0, 8'd0, "");
      do_reset();
      check("R11", host_rdata, 8'h00);
      rd_at(4'd4, 8'h1B, "R11");
      rd_at(4'd4, 8'h1D, "R11");

      summary();
      $finish;
   end
endmodule